// File: doc/BRIEF.md
# Bus parity checker and generator

This block sits between a processor and its external buses and guards them with odd parity. On every qualified access it checks four fields separately: the read-data bus, the address bus, a joint field made of the address-space identifier and the transfer size, and the control bus coming back from the integer unit. It also produces the parity bits that travel with outgoing write data and with the control word it drives toward the integer unit.

Any failed check pulls the active-low memory-exception output low for one clock. A small fault record keeps the class of the first error and the address of the failing access. It holds that error until it is cleared. One active-low input turns off every external check, and generation carries on as normal while checks are off.

The record is run by a two-state machine. `ST_CLEAN` means nothing is recorded and `ST_LOGGED` means an error is held. The transition CAPTURE (`ST_CLEAN`→`ST_LOGGED`) fires on a failing access. RELEASE (`ST_LOGGED`→`ST_CLEAN`) fires on a clear with no failing access in the same cycle. RECAPTURE (`ST_LOGGED`→`ST_LOGGED`) fires on a clear that arrives together with a failing access, and stores the new error. Any other cycle in `ST_LOGGED` is HOLD.

Top module: `bus_parity_unit`

## Requirements
- R1: On a cycle with `acc_vld`=1, `par_off_n`=1 and `data_wr`=0, a data error is raised when `data_bus` plus `data_par_in` holds an even number of ones. Odd parity is correct. With `data_wr`=1 the data field is not checked.
- R2: On a qualified access (`acc_vld`=1, `par_off_n`=1), an address error is raised when `addr` plus `addr_par` holds an even number of ones.
- R3: On a qualified access, a space/size error is raised when `{asi, xfer_size}` plus `space_par` holds an even number of ones.
- R4: On a qualified access, a control error is raised when `ctrl_in` plus `ctrl_par_in` holds an even number of ones.
- R5: `data_par_out` and `ctrl_par_out` are combinational odd-parity bits. `data_bus` plus `data_par_out` always holds an odd number of ones, and `ctrl_drv` plus `ctrl_par_out` does the same. This holds whatever `par_off_n` is.
- R6: `mexc_n` is 0 in exactly the clock cycle after a qualified access with any error. In every other cycle it is 1.
- R7: While `par_off_n`=0, no check fires. `mexc_n` stays 1 and the fault record is unchanged.
- R8: The first error moves the record to `ST_LOGGED`. `fault_vld` becomes 1, `fault_code` is set (data=1, address=2, space/size=3, control=4) and `fault_addr` takes the access address, all in the same cycle that `mexc_n` is low. Later errors pulse `mexc_n` but leave the record as it is.
- R9: When several checks fail on one access, `fault_code` takes the lowest code among them.
- R10: `fsr_clr`=1 in `ST_LOGGED` with no error clears the record (`fault_vld`=0, code 0, address 0) on the next cycle. If a failing access comes in the same cycle, the new error is recorded instead.
- R11: After reset, `mexc_n`=1, `fault_vld`=0, `fault_code`=0 and `fault_addr`=0.
- R12: Bus values with `acc_vld`=0 have no effect on `mexc_n` or on the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_off_n | input | 1 | Active-low disable of all external checks |
| acc_vld | input | 1 | Access strobe that qualifies the checks |
| data_wr | input | 1 | 1 = write access (data generated, not checked) |
| data_bus | input | DATA_W | Data bus value |
| data_par_in | input | 1 | Parity received with read data |
| data_par_out | output | 1 | Generated odd parity for data_bus |
| addr | input | ADDR_W | Access address |
| addr_par | input | 1 | Address parity |
| asi | input | ASI_W | Address-space identifier |
| xfer_size | input | SIZE_W | Transfer size |
| space_par | input | 1 | Joint parity over asi and xfer_size |
| ctrl_in | input | CTRL_W | Control word from the integer unit |
| ctrl_par_in | input | 1 | Parity of ctrl_in |
| ctrl_drv | input | CTRL_W | Control word driven to the integer unit |
| ctrl_par_out | output | 1 | Generated odd parity for ctrl_drv |
| fsr_clr | input | 1 | Clear the fault record |
| mexc_n | output | 1 | Active-low memory-exception pulse |
| fault_vld | output | 1 | Fault record holds an error |
| fault_code | output | 3 | Recorded error class |
| fault_addr | output | ADDR_W | Address of the recorded access |

## Verification
The assertions take `acc_vld`, `par_off_n` and `fsr_clr` to be driven to known values from reset onward, and assume they change only between clock edges. The bench meets this by driving every input at the falling edge and holding all strobes low during reset. A narrow parameter set makes it possible to sweep every value of each checked field with both parity bits. Every single failure and every combination of failing fields is tried, both with checks on and with checks off.

// File: rtl/bpu_pkg.sv
`timescale 1ns/1ps
package bpu_pkg;
    localparam int NCHK = 4;

    typedef enum logic [2:0] {
        FC_NONE  = 3'd0,
        FC_DATA  = 3'd1,
        FC_ADDR  = 3'd2,
        FC_SPACE = 3'd3,
        FC_CTRL  = 3'd4
    } fault_code_e;

    typedef enum logic {
        ST_CLEAN  = 1'b0,
        ST_LOGGED = 1'b1
    } fsm_state_e;
endpackage

// File: rtl/bpu_par_check.sv
`timescale 1ns/1ps
module bpu_par_check #(
    parameter int W = 8
) (
    input  logic [W-1:0] field,
    input  logic         par,
    input  logic         en,
    output logic         err
);
    // odd parity: field plus parity bit must carry an odd count of ones
    logic ones_odd;
    always_comb begin
        ones_odd = (^field) ^ par;
        err      = en & ~ones_odd;
    end
endmodule

// File: rtl/bpu_par_gen.sv
`timescale 1ns/1ps
module bpu_par_gen #(
    parameter int W = 8
) (
    input  logic [W-1:0] field,
    output logic         par
);
    always_comb par = ~(^field);
endmodule

// File: rtl/bpu_prio_sel.sv
`timescale 1ns/1ps
module bpu_prio_sel
    import bpu_pkg::*;
(
    input  logic [NCHK-1:0] fails,
    output fault_code_e     code,
    output logic            any
);
    always_comb begin
        code = FC_NONE;
        // walk from highest to lowest so the lowest index wins
        for (int i = NCHK - 1; i >= 0; i--) begin
            if (fails[i]) code = fault_code_e'(3'(i + 1));
        end
        any = |fails;
    end
endmodule

// File: rtl/bpu_fault_fsm.sv
`timescale 1ns/1ps
module bpu_fault_fsm
    import bpu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  fault_code_e       hit_code,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic              clr,
    output logic              mexc_n,
    output logic              fault_vld,
    output logic [2:0]        fault_code,
    output logic [ADDR_W-1:0] fault_addr
);
    fsm_state_e        state_q, state_d;
    logic              capture;
    logic              release_rec;
    logic [2:0]        code_q;
    logic [ADDR_W-1:0] addr_q;
    logic              mexc_q;

    // next-state: CAPTURE, HOLD, RELEASE, RECAPTURE
    always_comb begin
        state_d     = state_q;
        capture     = 1'b0;
        release_rec = 1'b0;
        unique case (state_q)
            ST_CLEAN: begin
                if (hit) begin
                    state_d = ST_LOGGED;
                    capture = 1'b1;
                end
            end
            ST_LOGGED: begin
                if (clr && hit) begin
                    state_d = ST_LOGGED;
                    capture = 1'b1;
                end else if (clr) begin
                    state_d     = ST_CLEAN;
                    release_rec = 1'b1;
                end
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAN;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mexc_q <= 1'b1;
            code_q <= 3'd0;
            addr_q <= '0;
        end else begin
            mexc_q <= ~hit;
            if (capture) begin
                code_q <= hit_code;
                addr_q <= hit_addr;
            end else if (release_rec) begin
                code_q <= 3'd0;
                addr_q <= '0;
            end
        end
    end

    assign mexc_n     = mexc_q;
    assign fault_vld  = (state_q == ST_LOGGED);
    assign fault_code = code_q;
    assign fault_addr = addr_q;
endmodule

// File: rtl/bus_parity_unit.sv
`timescale 1ns/1ps
module bus_parity_unit
    import bpu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int ASI_W  = 8,
    parameter int SIZE_W = 2,
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_off_n,
    input  logic              acc_vld,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_bus,
    input  logic              data_par_in,
    output logic              data_par_out,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_par,
    input  logic [ASI_W-1:0]  asi,
    input  logic [SIZE_W-1:0] xfer_size,
    input  logic              space_par,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic              ctrl_par_in,
    input  logic [CTRL_W-1:0] ctrl_drv,
    output logic              ctrl_par_out,
    input  logic              fsr_clr,
    output logic              mexc_n,
    output logic              fault_vld,
    output logic [2:0]        fault_code,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int SPACE_W = ASI_W + SIZE_W;

    logic              chk_en;
    logic              data_en;
    logic [NCHK-1:0]   fails;
    logic [SPACE_W-1:0] space_field;
    fault_code_e       sel_code;
    logic              any_fail;

    assign chk_en      = acc_vld & par_off_n;
    assign data_en     = chk_en & ~data_wr;
    assign space_field = {asi, xfer_size};

    // index order sets the fault code: 0=data,1=addr,2=space,3=ctrl
    bpu_par_check #(.W(DATA_W)) u_chk_data (
        .field(data_bus), .par(data_par_in), .en(data_en), .err(fails[0]));
    bpu_par_check #(.W(ADDR_W)) u_chk_addr (
        .field(addr), .par(addr_par), .en(chk_en), .err(fails[1]));
    bpu_par_check #(.W(SPACE_W)) u_chk_space (
        .field(space_field), .par(space_par), .en(chk_en), .err(fails[2]));
    bpu_par_check #(.W(CTRL_W)) u_chk_ctrl (
        .field(ctrl_in), .par(ctrl_par_in), .en(chk_en), .err(fails[3]));

    bpu_par_gen #(.W(DATA_W)) u_gen_data (.field(data_bus), .par(data_par_out));
    bpu_par_gen #(.W(CTRL_W)) u_gen_ctrl (.field(ctrl_drv), .par(ctrl_par_out));

    bpu_prio_sel u_sel (.fails(fails), .code(sel_code), .any(any_fail));

    bpu_fault_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (any_fail),
        .hit_code   (sel_code),
        .hit_addr   (addr),
        .clr        (fsr_clr),
        .mexc_n     (mexc_n),
        .fault_vld  (fault_vld),
        .fault_code (fault_code),
        .fault_addr (fault_addr)
    );
endmodule

// File: rtl/bpu_chk.sv
`timescale 1ns/1ps
module bpu_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              par_off_n,
    input logic              acc_vld,
    input logic              fsr_clr,
    input logic              mexc_n,
    input logic              fault_vld,
    input logic [2:0]        fault_code,
    input logic [ADDR_W-1:0] fault_addr
);
    // R6
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mexc_n |-> ($past(acc_vld) && $past(par_off_n)));

    // R6
    pulse_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mexc_n |-> fault_vld);

    // R7
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_off_n |=> mexc_n);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |=> mexc_n);

    // R8
    hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && !fsr_clr) |=> (fault_vld && $stable(fault_code) && $stable(fault_addr)));

    // R8
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |-> (fault_code >= 3'd1 && fault_code <= 3'd4));

    // R10
    clr_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vld && fsr_clr) |=> (!fault_vld || !mexc_n));
endmodule

bind bus_parity_unit bpu_chk #(.ADDR_W(ADDR_W)) u_bpu_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_off_n  (par_off_n),
    .acc_vld    (acc_vld),
    .fsr_clr    (fsr_clr),
    .mexc_n     (mexc_n),
    .fault_vld  (fault_vld),
    .fault_code (fault_code),
    .fault_addr (fault_addr)
);

// File: tb/tb_bus_parity_unit.sv
`timescale 1ns/1ps
module tb_bus_parity_unit;
    localparam int DW = 4, AW = 3, SW = 2, ZW = 1, CW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic off_n, vld, wr, dp, ap, sp, cp, clr;
    logic [DW-1:0] d;
    logic [AW-1:0] a;
    logic [SW-1:0] s;
    logic [ZW-1:0] z;
    logic [CW-1:0] ci, cd;
    logic dpo, cpo, mexc_n, fvld;
    logic [2:0] fcode;
    logic [AW-1:0] faddr;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    bus_parity_unit #(.DATA_W(DW), .ADDR_W(AW), .ASI_W(SW), .SIZE_W(ZW), .CTRL_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .par_off_n(off_n), .acc_vld(vld), .data_wr(wr),
        .data_bus(d), .data_par_in(dp), .data_par_out(dpo), .addr(a), .addr_par(ap),
        .asi(s), .xfer_size(z), .space_par(sp), .ctrl_in(ci), .ctrl_par_in(cp),
        .ctrl_drv(cd), .ctrl_par_out(cpo), .fsr_clr(clr), .mexc_n(mexc_n),
        .fault_vld(fvld), .fault_code(fcode), .fault_addr(faddr));

    // odd-parity bit for a value: 1 when the value has an even count of ones
    function automatic logic gp(int v);
        return ($countones(v) % 2) == 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_good();
        dp = gp(int'(d));
        ap = gp(int'(a));
        sp = gp(int'({s, z}));
        cp = gp(int'(ci));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        vld = 1'b0;
        clr = 1'b0;
    endtask

    task automatic expect_rec(bit e_mexc, bit e_vld, int e_code, int e_addr, string req);
        chk(mexc_n == e_mexc, {req, " mexc_n"}, int'(mexc_n), int'(e_mexc));
        chk(fvld == e_vld, {req, " fault_vld"}, int'(fvld), int'(e_vld));
        chk(int'(fcode) == e_code, {req, " fault_code"}, int'(fcode), e_code);
        chk(int'(faddr) == e_addr, {req, " fault_addr"}, int'(faddr), e_addr);
    endtask

    // access, check record, idle cycle, clear
    task automatic run_one(bit e_err, int e_code, string req);
        int ea;
        ea = e_err ? int'(a) : 0;
        vld = 1'b1;
        step();
        expect_rec(!e_err, e_err, e_err ? e_code : 0, ea, req);
        step();
        chk(mexc_n == 1'b1, "R6 pulse width", int'(mexc_n), 1);
        clr = 1'b1;
        step();
        chk(fvld == 1'b0, "R10 cleared", int'(fvld), 0);
    endtask

    initial begin
        off_n = 1'b1; vld = 1'b0; wr = 1'b0; clr = 1'b0;
        d = '0; a = '0; s = '0; z = '0; ci = '0; cd = '0;
        set_good();
        repeat (3) @(negedge clk);
        expect_rec(1'b1, 1'b0, 0, 0, "R11 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_rec(1'b1, 1'b0, 0, 0, "R11 after reset");

        // R1 data sweep
        for (int i = 0; i < 32; i++) begin
            d = DW'(i); a = AW'(i); set_good(); dp = i[4];
            run_one(dp != gp(int'(d)), 1, "R1 data");
        end
        // R1 writes skip the data check
        d = 4'b0001; a = 3'd2; set_good(); dp = ~dp; wr = 1'b1;
        run_one(1'b0, 0, "R1 write not checked");
        wr = 1'b0;

        // R2 address sweep
        for (int i = 0; i < 16; i++) begin
            a = AW'(i); d = 4'd3; set_good(); ap = i[3];
            run_one(ap != gp(int'(a)), 2, "R2 addr");
        end

        // R3 space/size sweep
        for (int i = 0; i < 16; i++) begin
            {s, z} = 3'(i); a = 3'(i + 1); set_good(); sp = i[3];
            run_one(sp != gp(int'({s, z})), 3, "R3 space");
        end

        // R4 control sweep
        for (int i = 0; i < 8; i++) begin
            ci = CW'(i); a = 3'(i); set_good(); cp = i[2];
            run_one(cp != gp(int'(ci)), 4, "R4 ctrl");
        end

        // R5 generation sweeps, checks on and off
        for (int i = 0; i < 32; i++) begin
            off_n = i[4];
            d = DW'(i); cd = CW'(i);
            #1;
            chk(dpo == gp(int'(d)), "R5 data gen", int'(dpo), int'(gp(int'(d))));
            chk(cpo == gp(int'(cd)), "R5 ctrl gen", int'(cpo), int'(gp(int'(cd))));
        end
        off_n = 1'b1;
        @(negedge clk);

        // R9 every combination of failing fields
        for (int m = 0; m < 16; m++) begin
            int lo;
            d = 4'd5; a = 3'(m); s = 2'd1; z = 1'b0; ci = 2'd2; set_good();
            if (m[0]) dp = ~dp;
            if (m[1]) ap = ~ap;
            if (m[2]) sp = ~sp;
            if (m[3]) cp = ~cp;
            lo = 0;
            for (int b = 3; b >= 0; b--) if (m[b]) lo = b + 1;
            run_one(m != 0, lo, "R9 priority");
        end

        // R7 checks off: nothing fires
        for (int m = 1; m < 16; m++) begin
            off_n = 1'b0;
            d = 4'd6; a = 3'(m); set_good();
            if (m[0]) dp = ~dp;
            if (m[1]) ap = ~ap;
            if (m[2]) sp = ~sp;
            if (m[3]) cp = ~cp;
            vld = 1'b1;
            step();
            expect_rec(1'b1, 1'b0, 0, 0, "R7 off");
        end
        off_n = 1'b1;

        // R12 strobe low: bad parity ignored
        d = 4'd1; a = 3'd7; set_good(); dp = ~dp; ap = ~ap;
        step();
        expect_rec(1'b1, 1'b0, 0, 0, "R12 no strobe");

        // R8 first error held
        d = 4'd1; a = 3'd5; set_good(); ap = ~ap; vld = 1'b1;
        step();
        expect_rec(1'b0, 1'b1, 2, 5, "R8 first");
        a = 3'd6; set_good(); dp = ~dp; vld = 1'b1;
        step();
        expect_rec(1'b0, 1'b1, 2, 5, "R8 held");
        // R7 off with held record
        off_n = 1'b0; a = 3'd1; set_good(); cp = ~cp; vld = 1'b1;
        step();
        expect_rec(1'b1, 1'b1, 2, 5, "R7 record kept");
        off_n = 1'b1;
        // R10 clear together with a new error
        a = 3'd3; set_good(); cp = ~cp; vld = 1'b1; clr = 1'b1;
        step();
        expect_rec(1'b0, 1'b1, 4, 3, "R10 recapture");
        clr = 1'b1;
        step();
        expect_rec(1'b1, 1'b0, 0, 0, "R10 release");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule